// File: doc/BRIEF.md
# Configurable Frame CRC Engine

This block folds frame bytes into a cyclic redundancy check whose width, generator polynomial, start value, final inversion mask, input bit order, output bit reversal and output byte order are all chosen at run time. One byte is absorbed per clock. A restart strobe reloads the start value, so one frame can hold several independently protected segments, each closed by its own CRC field.

At the end of a segment the owner either asks the engine to emit the finished CRC as a burst of bytes on consecutive cycles, or asks it to verify one. In verify mode the next CRC-sized group of incoming bytes is compared, byte by byte, against the value the engine would have emitted. Those bytes are not folded into the running CRC. A one-cycle completion pulse reports the verdict, and a mismatch also raises a sticky error that stays set until the next restart.

Top module: `frame_crc_engine`

## Requirements
- R1: After reset, crc_valid_o, done_o, pass_o and err_o are all 0.
- R2: cfg_width_i selects the CRC width: 0 gives 8, 1 gives 16, 2 gives 24 and 3 gives 32 bits. After emit_i is sampled high, crc_valid_o is 1 for exactly width/8 consecutive cycles, starting the cycle after, with one CRC byte per cycle on crc_byte_o.
- R3: The CRC is the usual shift-left register. The feedback bit (register MSB XOR input bit) adds cfg_poly_i, taken in its low width bits. With width 32, a cfg_poly_i of zero selects polynomial 0x04C11DB7.
- R4: When cfg_lsb_first_i is 1, each data byte is fed bit 0 first; otherwise bit 7 first.
- R5: When cfg_bitrev_i is 1, the finished register value is bit-reversed across the CRC width before the final mask is applied.
- R6: When cfg_lsbyte_first_i is 1, the least significant CRC byte is sent or compared first; otherwise the most significant byte goes first.
- R7: The register starts from the low width bits of cfg_init_i, and the emitted value is XORed with the low width bits of cfg_xorout_i.
- R8: init_i restarts the CRC from the start value. A byte valid in the same cycle is the first byte of the new segment, so consecutive segments of a frame get independent CRCs.
- R9: A byte valid in the cycle of emit_i or check_i is included in the captured CRC. Bytes arriving while an emission is under way keep folding into the running CRC.
- R10: After check_i, the next width/8 valid bytes are compared against the bytes emission would produce, in the same order, and are not folded. The cycle after the last of them, done_o pulses for one cycle with pass_o = 1 only if every byte matched. If check_i and emit_i are both high, check wins.
- R11: A failed comparison sets err_o. err_o stays 1 until init_i is sampled high, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Restart CRC from start value, clear error |
| data_valid_i | input | 1 | data_i carries a frame byte |
| data_i | input | 8 | Frame byte |
| emit_i | input | 1 | Capture the CRC and send it out |
| check_i | input | 1 | Capture the CRC and compare it with the next bytes |
| cfg_width_i | input | 2 | Width code (0:8, 1:16, 2:24, 3:32) |
| cfg_poly_i | input | 32 | Generator polynomial, low width bits |
| cfg_init_i | input | 32 | Start value, low width bits |
| cfg_xorout_i | input | 32 | Final XOR mask, low width bits |
| cfg_lsb_first_i | input | 1 | Feed data bits LSB first |
| cfg_bitrev_i | input | 1 | Bit-reverse the finished CRC |
| cfg_lsbyte_first_i | input | 1 | Send or compare the low CRC byte first |
| crc_byte_o | output | 8 | Emitted CRC byte |
| crc_valid_o | output | 1 | crc_byte_o is valid |
| done_o | output | 1 | One-cycle pulse ending a comparison |
| pass_o | output | 1 | Comparison result, valid with done_o |
| err_o | output | 1 | Sticky comparison failure |

## Verification
Two functions can fall in the same cycle: the segment restart and the absorption of a byte, and the capture for emission and the absorption of a byte. The bench drives init_i together with the first byte of a second segment and compares the second CRC with a reference that covers only that segment. It also drives emit_i with the last byte of a message and feeds a further byte during the emission burst. The first burst must cover the message including that last byte, and a second emission must cover the extra byte as well. Known check values of common CRC variants over the string "123456789" tie the width, polynomial, bit-order and byte-order options to published results.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned MAX_W   = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned MAX_NB  = MAX_W / BYTE_W;
  localparam int unsigned CNT_W   = $clog2(MAX_NB + 1);

  typedef enum logic [1:0] {
    CW8  = 2'd0,
    CW16 = 2'd1,
    CW24 = 2'd2,
    CW32 = 2'd3
  } crc_width_e;
endpackage

// File: rtl/crc_byte_step.sv
// One byte folded into a top-aligned CRC register, eight unrolled shift steps.
module crc_byte_step #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] crc_i,
  input  logic [W-1:0] poly_i,
  input  logic [7:0]   data_i,
  input  logic         lsb_first_i,
  output logic [W-1:0] crc_o
);
  for (genvar g = 0; g < 8; g++) begin : g_bit
    logic [W-1:0] prev;
    logic [W-1:0] nxt;
    logic         din;
    logic         fb;
    if (g == 0) begin : g_first
      assign prev = crc_i;
    end else begin : g_chain
      assign prev = g_bit[g-1].nxt;
    end
    assign din = lsb_first_i ? data_i[g] : data_i[7-g];
    assign fb  = prev[W-1] ^ din;
    assign nxt = {prev[W-2:0], 1'b0} ^ (fb ? poly_i : '0);
  end

  assign crc_o = g_bit[7].nxt;
endmodule

// File: rtl/crc_finalize.sv
// Top-aligned register -> reflected/masked value -> bytes in send order (byte 0 low).
module crc_finalize #(
  parameter int unsigned W     = 32,
  parameter int unsigned CNT_W = 3
) (
  input  logic [W-1:0]     crc_a_i,
  input  logic [4:0]       align_i,
  input  logic [CNT_W-1:0] nbytes_i,
  input  logic [W-1:0]     xorout_i,
  input  logic             bitrev_i,
  input  logic             lsbyte_first_i,
  output logic [W-1:0]     ordered_o
);
  localparam int unsigned NB = W / 8;

  logic [W-1:0] mask;
  logic [W-1:0] plain;
  logic [W-1:0] refl;
  logic [W-1:0] fin;

  assign mask  = {W{1'b1}} >> align_i;
  assign plain = crc_a_i >> align_i;

  // full-width reversal of the top-aligned register is the width-wide reversal, low-aligned
  always_comb begin
    refl = '0;
    for (int i = 0; i < int'(W); i++) refl[i] = crc_a_i[W-1-i];
  end

  assign fin = (bitrev_i ? refl : plain) ^ (xorout_i & mask);

  always_comb begin
    ordered_o = '0;
    for (int k = 0; k < int'(NB); k++) begin
      if (k < int'(nbytes_i)) begin
        if (lsbyte_first_i) ordered_o[8*k +: 8] = fin[8*k +: 8];
        else                ordered_o[8*k +: 8] = fin[8*(int'(nbytes_i)-1-k) +: 8];
      end
    end
  end
endmodule

// File: rtl/crc_serdes.sv
// Emits a captured CRC byte by byte, or compares incoming bytes against it.
module crc_serdes #(
  parameter int unsigned W     = 32,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             cap_emit_i,
  input  logic             cap_check_i,
  input  logic [W-1:0]     value_i,
  input  logic [CNT_W-1:0] nbytes_i,
  input  logic             data_valid_i,
  input  logic [7:0]       data_i,
  output logic             checking_o,
  output logic [7:0]       byte_o,
  output logic             byte_valid_o,
  output logic             done_o,
  output logic             pass_o,
  output logic             err_o
);
  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             chk_q;
  logic             miss_q;
  logic             done_q;
  logic             pass_q;
  logic             err_q;

  logic cap, active, step_emit, step_chk, mis_now, last, fail_now;

  assign cap       = cap_emit_i | cap_check_i;
  assign active    = (cnt_q != '0);
  assign step_emit = !cap && !init_i && active && !chk_q;
  assign step_chk  = !cap && !init_i && active && chk_q && data_valid_i;
  assign mis_now   = (data_i != sh_q[7:0]);
  assign last      = (cnt_q == CNT_W'(1));
  assign fail_now  = step_chk && last && (miss_q || mis_now);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      chk_q  <= 1'b0;
      miss_q <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cap) begin
        sh_q   <= value_i;
        cnt_q  <= nbytes_i;
        chk_q  <= cap_check_i;
        miss_q <= 1'b0;
      end else if (init_i) begin
        cnt_q <= '0;
      end else if (step_emit) begin
        sh_q  <= sh_q >> 8;
        cnt_q <= cnt_q - CNT_W'(1);
      end else if (step_chk) begin
        sh_q   <= sh_q >> 8;
        cnt_q  <= cnt_q - CNT_W'(1);
        miss_q <= miss_q | mis_now;
        if (last) begin
          done_q <= 1'b1;
          pass_q <= !(miss_q || mis_now);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_q <= 1'b0;
    else if (init_i)   err_q <= 1'b0;
    else if (fail_now) err_q <= 1'b1;
  end

  assign checking_o   = active && chk_q;
  assign byte_valid_o = active && !chk_q;
  assign byte_o       = sh_q[7:0];
  assign done_o       = done_q;
  assign pass_o       = pass_q;
  assign err_o        = err_q;

  // R11
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !init_i |=> err_q);
  // R11
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !err_q);
  // R10
  err_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> done_q && !pass_q);
  // R10
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(chk_q && data_valid_i));
endmodule

// File: rtl/frame_crc_engine.sv
module frame_crc_engine
  import crc_pkg::*;
#(
  parameter logic [31:0] DFLT_POLY32 = 32'h04C1_1DB7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        data_valid_i,
  input  logic [7:0]  data_i,
  input  logic        emit_i,
  input  logic        check_i,
  input  logic [1:0]  cfg_width_i,
  input  logic [31:0] cfg_poly_i,
  input  logic [31:0] cfg_init_i,
  input  logic [31:0] cfg_xorout_i,
  input  logic        cfg_lsb_first_i,
  input  logic        cfg_bitrev_i,
  input  logic        cfg_lsbyte_first_i,
  output logic [7:0]  crc_byte_o,
  output logic        crc_valid_o,
  output logic        done_o,
  output logic        pass_o,
  output logic        err_o
);
  localparam int unsigned W = MAX_W;

  crc_width_e       width;
  logic [1:0]       pad_bytes;
  logic [4:0]       align;
  logic [CNT_W-1:0] nbytes;
  logic [W-1:0]     poly_eff, poly_a, init_a;
  logic [W-1:0]     crc_q, base, stepped, nxt, ordered;
  logic             checking, fold;

  assign width     = crc_width_e'(cfg_width_i);
  assign pad_bytes = 2'd3 - cfg_width_i;
  assign align     = {pad_bytes, 3'b000};
  assign nbytes    = CNT_W'(cfg_width_i) + CNT_W'(1);

  assign poly_eff = (width == CW32 && cfg_poly_i == '0) ? DFLT_POLY32 : cfg_poly_i;
  assign poly_a   = poly_eff << align;
  assign init_a   = cfg_init_i << align;

  assign fold = data_valid_i && !checking;
  assign base = init_i ? init_a : crc_q;

  crc_byte_step #(.W(W)) u_step (
    .crc_i       (base),
    .poly_i      (poly_a),
    .data_i      (data_i),
    .lsb_first_i (cfg_lsb_first_i),
    .crc_o       (stepped)
  );

  assign nxt = fold ? stepped : base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= '0;
    else         crc_q <= nxt;
  end

  crc_finalize #(.W(W), .CNT_W(CNT_W)) u_fin (
    .crc_a_i        (nxt),
    .align_i        (align),
    .nbytes_i       (nbytes),
    .xorout_i       (cfg_xorout_i),
    .bitrev_i       (cfg_bitrev_i),
    .lsbyte_first_i (cfg_lsbyte_first_i),
    .ordered_o      (ordered)
  );

  crc_serdes #(.W(W), .CNT_W(CNT_W)) u_ser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .init_i       (init_i),
    .cap_emit_i   (emit_i),
    .cap_check_i  (check_i),
    .value_i      (ordered),
    .nbytes_i     (nbytes),
    .data_valid_i (data_valid_i),
    .data_i       (data_i),
    .checking_o   (checking),
    .byte_o       (crc_byte_o),
    .byte_valid_o (crc_valid_o),
    .done_o       (done_o),
    .pass_o       (pass_o),
    .err_o        (err_o)
  );

  // R8
  init_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i && !fold |=> crc_q == $past(init_a));
  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_i && !data_valid_i |=> $stable(crc_q));
  // R10
  check_nofold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    checking && !init_i |=> $stable(crc_q));
endmodule

// File: tb/frame_crc_engine_test.sv
`timescale 1ns/1ps
module frame_crc_engine_test;
  typedef struct packed {
    logic [1:0]  w;
    logic [31:0] poly;
    logic [31:0] init;
    logic [31:0] xo;
    logic        lsb;
    logic        rev;
    logic        lsby;
    logic [31:0] exp;   // bytes in send order, first byte in [7:0]
  } vec_t;

  // check strings over "123456789"
  localparam int NV = 8;
  localparam vec_t VECS [0:NV-1] = '{
    '{2'd3, 32'h04C11DB7, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b1, 32'hCBF43926},
    '{2'd3, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 32'h2639F4CB},
    '{2'd1, 32'h00001021, 32'h0000FFFF, 32'h00000000, 1'b0, 1'b0, 1'b0, 32'h0000B129},
    '{2'd1, 32'h00001021, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 1'b1, 32'h000031C3},
    '{2'd1, 32'h00008005, 32'h00000000, 32'h00000000, 1'b1, 1'b1, 1'b1, 32'h0000BB3D},
    '{2'd0, 32'h00000007, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 1'b0, 32'h000000F4},
    '{2'd2, 32'h00864CFB, 32'h00B704CE, 32'h00000000, 1'b0, 1'b0, 1'b0, 32'h0002CF21},
    '{2'd3, 32'h04C11DB7, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b0, 1'b0, 32'hE7E67603}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        init_i = 1'b0, data_valid_i = 1'b0, emit_i = 1'b0, check_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic [1:0]  cfg_width_i = '0;
  logic [31:0] cfg_poly_i = '0, cfg_init_i = '0, cfg_xorout_i = '0;
  logic        cfg_lsb_first_i = 1'b0, cfg_bitrev_i = 1'b0, cfg_lsbyte_first_i = 1'b0;
  logic [7:0]  crc_byte_o;
  logic        crc_valid_o, done_o, pass_o, err_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mbuf [0:15];

  always #4 clk = ~clk;

  frame_crc_engine uut (
    .clk_i(clk), .rst_ni(rst_ni), .init_i(init_i), .data_valid_i(data_valid_i),
    .data_i(data_i), .emit_i(emit_i), .check_i(check_i), .cfg_width_i(cfg_width_i),
    .cfg_poly_i(cfg_poly_i), .cfg_init_i(cfg_init_i), .cfg_xorout_i(cfg_xorout_i),
    .cfg_lsb_first_i(cfg_lsb_first_i), .cfg_bitrev_i(cfg_bitrev_i),
    .cfg_lsbyte_first_i(cfg_lsbyte_first_i), .crc_byte_o(crc_byte_o),
    .crc_valid_o(crc_valid_o), .done_o(done_o), .pass_o(pass_o), .err_o(err_o)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference built from the bit-serial definition
  function automatic logic [31:0] model(input vec_t c, input int first, input int n);
    int w = 8 * (int'(c.w) + 1);
    int nb = w / 8;
    logic [31:0] mask = 32'hFFFFFFFF >> (32 - w);
    logic [31:0] p = (c.w == 2'd3 && c.poly == 0) ? 32'h04C11DB7 : c.poly;
    logic [31:0] r = c.init & mask;
    logic [31:0] t, o;
    for (int k = first; k < first + n; k++)
      for (int i = 0; i < 8; i++) begin
        logic b, fb;
        b  = c.lsb ? mbuf[k][i] : mbuf[k][7-i];
        fb = r[w-1] ^ b;
        r  = ((r << 1) & mask) ^ (fb ? (p & mask) : 32'h0);
      end
    if (c.rev) begin
      t = 0;
      for (int i = 0; i < w; i++) t[i] = r[w-1-i];
      r = t;
    end
    r = r ^ (c.xo & mask);
    o = 0;
    for (int k = 0; k < nb; k++)
      o[8*k +: 8] = c.lsby ? r[8*k +: 8] : r[8*(nb-1-k) +: 8];
    return o;
  endfunction

  task automatic set_cfg(input vec_t v);
    cfg_width_i = v.w; cfg_poly_i = v.poly; cfg_init_i = v.init; cfg_xorout_i = v.xo;
    cfg_lsb_first_i = v.lsb; cfg_bitrev_i = v.rev; cfg_lsbyte_first_i = v.lsby;
  endtask

  task automatic pulse_init();
    init_i = 1'b1; @(negedge clk); init_i = 1'b0;
  endtask

  task automatic feed(input logic [7:0] b);
    data_valid_i = 1'b1; data_i = b; @(negedge clk); data_valid_i = 1'b0;
  endtask

  // reads the burst; call right after the edge that sampled emit_i
  task automatic collect(input int n, input string req, output logic [31:0] got);
    got = 0;
    for (int k = 0; k < n; k++) begin
      if (!crc_valid_o) chk(1'b0, req, 32'(k), 32'(n));
      got[8*k +: 8] = crc_byte_o;
      @(negedge clk);
    end
    chk(crc_valid_o == 1'b0, "R2 burst length", 32'(crc_valid_o), 32'h0);
  endtask

  task automatic emit_get(input int n, input string req, output logic [31:0] got);
    emit_i = 1'b1; @(negedge clk); emit_i = 1'b0;
    collect(n, req, got);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] got, exp;
    vec_t v;
    for (int k = 0; k < 9; k++) mbuf[k] = 8'h31 + 8'(k);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk({crc_valid_o, done_o, pass_o, err_o} == 4'b0, "R1 reset outputs",
        32'({crc_valid_o, done_o, pass_o, err_o}), 32'h0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      set_cfg(VECS[i]);
      pulse_init();
      for (int k = 0; k < 9; k++) feed(mbuf[k]);
      emit_get(int'(VECS[i].w) + 1, "R2 burst short", got);
      chk(got == VECS[i].exp, $sformatf("R3/R4/R5/R6/R7 vector %0d", i), got, VECS[i].exp);
    end

    // R8: restart with the first byte of segment two in the same cycle
    v = VECS[2];
    set_cfg(v);
    pulse_init();
    for (int k = 0; k < 4; k++) feed(mbuf[k]);
    emit_get(2, "R8 seg1", got);
    exp = model(v, 0, 4);
    chk(got == exp, "R8 segment 1", got, exp);
    init_i = 1'b1; data_valid_i = 1'b1; data_i = mbuf[4];
    @(negedge clk);
    init_i = 1'b0; data_valid_i = 1'b0;
    for (int k = 5; k < 9; k++) feed(mbuf[k]);
    emit_get(2, "R8 seg2", got);
    exp = model(v, 4, 5);
    chk(got == exp, "R8 segment 2", got, exp);

    // R9: emit together with a byte, then a byte during the burst
    v = VECS[0];
    set_cfg(v);
    pulse_init();
    for (int k = 0; k < 7; k++) feed(mbuf[k]);
    emit_i = 1'b1; data_valid_i = 1'b1; data_i = mbuf[7];
    @(negedge clk);
    emit_i = 1'b0; data_i = mbuf[8];   // still valid: folds during the burst
    got[7:0] = crc_byte_o;
    chk(crc_valid_o == 1'b1, "R9 burst start", 32'(crc_valid_o), 32'h1);
    @(negedge clk);
    data_valid_i = 1'b0;
    for (int k = 1; k < 4; k++) begin
      got[8*k +: 8] = crc_byte_o;
      @(negedge clk);
    end
    exp = model(v, 0, 8);
    chk(got == exp, "R9 capture with byte", got, exp);
    emit_get(4, "R9 second", got);
    chk(got == 32'hCBF43926, "R9 fold during burst", got, 32'hCBF43926);

    // R10: check passes, compared bytes not folded
    check_i = 1'b1; @(negedge clk); check_i = 1'b0;
    feed(8'h26); feed(8'h39); feed(8'hF4);
    chk(done_o == 1'b0, "R10 no early done", 32'(done_o), 32'h0);
    feed(8'hCB);
    chk(done_o && pass_o, "R10 pass", 32'({done_o, pass_o}), 32'h3);
    @(negedge clk);
    chk(done_o == 1'b0, "R10 single pulse", 32'(done_o), 32'h0);
    chk(err_o == 1'b0, "R11 no error on pass", 32'(err_o), 32'h0);
    emit_get(4, "R10 after check", got);
    chk(got == 32'hCBF43926, "R10 check bytes not folded", got, 32'hCBF43926);

    // R10/R11: failing compare, sticky error, clear by init
    check_i = 1'b1; @(negedge clk); check_i = 1'b0;
    feed(8'h26); feed(8'h00); feed(8'hF4); feed(8'hCB);
    chk(done_o && !pass_o, "R10 fail verdict", 32'({done_o, pass_o}), 32'h2);
    chk(err_o == 1'b1, "R11 error set", 32'(err_o), 32'h1);
    repeat (5) @(negedge clk);
    chk(err_o == 1'b1, "R11 error sticky", 32'(err_o), 32'h1);
    pulse_init();
    chk(err_o == 1'b0, "R11 cleared by init", 32'(err_o), 32'h0);

    // R3: default polynomial with an asymmetric byte order, from the model
    v = VECS[1];
    v.lsb = 1'b0; v.rev = 1'b1; v.xo = 32'h0F0F00FF;
    set_cfg(v);
    pulse_init();
    for (int k = 0; k < 9; k++) feed(mbuf[k]);
    emit_get(4, "R3 mixed", got);
    exp = model(v, 0, 9);
    chk(got == exp, "R3/R5 default poly mixed order", got, exp);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule